// File: doc/BRIEF.md
# Sub-word Lane Packer and Splitter

This block sits on both sides of a 64-bit SIMD ALU when vector elements are narrower than a full register. Elements of width w (8, 16, 32 or 64 bits) are stored little-endian across a run of consecutive 64-bit registers. Element n sits in register `base + (n*w)/64`, starting at bit `(n*w) mod 64`. Because a group of 64/w contiguous elements may start anywhere inside a register, one packed ALU word can straddle two registers.

The packer takes a starting element index, an element-width code, a lane count, the predicate bits and the two registers that the group touches. It returns the register offset that the caller must read, and one cycle later it returns the packed ALU operand with a per-lane enable. Disabled lanes are zeroed.

The splitter takes the packed ALU result, the same index and width, and the lane enables. It scatters each lane back to its home bytes. This produces at most two register writes, each with an 8-bit byte-enable, which leave untouched bytes preserved. The writes leave through a single write port, driven by a state machine with three states:
- `SP_IDLE`: ready for a new result.
- `SP_WR_LO`: write to the register at the computed offset.
- `SP_WR_HI`: write to the next register.

The transitions are:
- From `SP_IDLE`, an accepted result goes to `SP_WR_LO` when any low byte is enabled, otherwise to `SP_WR_HI` when any high byte is enabled, otherwise it stays in `SP_IDLE`.
- From `SP_WR_LO`, the machine goes to `SP_WR_HI` when high bytes remain, otherwise to `SP_IDLE`.
- From `SP_WR_HI`, the machine always returns to `SP_IDLE`.

Width codes are 0=8 bit, 1=16 bit, 2=32 bit and 3=64 bit. The lane count L is 8, 4, 2 or 1 respectively.

Top module: `subword_lane_xbar`

## Requirements
- R1: `pk_reg_off` equals `(pk_start*w)/64` combinationally, where w is the width selected by `pk_ew`.
- R2: One cycle after `pk_valid`, `op_valid` is high. Lane i of `op_data` (bits `i*w` upward) holds element `pk_start+i`, taken little-endian from `{pk_src_hi,pk_src_lo}` at bit `(pk_start+i)*w - 64*pk_reg_off`. `op_valid` is low one cycle after a cycle without `pk_valid`.
- R3: `op_lane_en[i]` is 1 exactly when `i < L`, `i < pk_count` and `pk_pred[i]` is 1. Bits at or above L are 0.
- R4: Every byte of `op_data` that belongs to a disabled lane is zero.
- R5: With width code 3, the packer passes `pk_src_lo` through unchanged in lane 0 when that lane is enabled.
- R6: For an accepted result, the first write goes to register offset `(res_start*w)/64`. Its byte-enable marks the bytes of enabled lanes that land in that register, and those bytes carry the lane data at their home positions.
- R7: Bytes that spill past the first register are written to offset+1 in the cycle right after the first write. When no low bytes are enabled, that write is the only one.
- R8: A write whose byte-enable would be all zero is never emitted, so a result with no enabled lane produces no write.
- R9: `res_ready` is high only while no write is pending. A `res_valid` presented while `res_ready` is low is ignored and produces no write.
- R10: After reset, `op_valid` and `wr_valid` are low and `res_ready` is high.
- R11: Bits of `res_lane_en` at or above L are ignored by the splitter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pk_valid | input | 1 | Packer request valid |
| pk_ew | input | 2 | Packer element-width code |
| pk_start | input | IDX_W | First element index of the group |
| pk_count | input | 4 | Number of active lanes (0 to 8) |
| pk_pred | input | 8 | Predicate bit per lane |
| pk_src_lo | input | 64 | Register at `pk_reg_off` |
| pk_src_hi | input | 64 | Register at `pk_reg_off`+1 |
| pk_reg_off | output | IDX_W | Register offset of the group's first element |
| op_valid | output | 1 | Packed operand valid |
| op_data | output | 64 | Packed ALU operand |
| op_lane_en | output | 8 | Per-lane enable for the ALU |
| res_valid | input | 1 | ALU result valid |
| res_ready | output | 1 | Splitter can accept a result |
| res_ew | input | 2 | Result element-width code |
| res_start | input | IDX_W | First element index of the result |
| res_lane_en | input | 8 | Lane enables of the result |
| res_data | input | 64 | Packed ALU result |
| wr_valid | output | 1 | Register write valid |
| wr_reg_off | output | IDX_W | Register offset of the write |
| wr_data | output | 64 | Write data |
| wr_be | output | 8 | Byte-enable of the write |

## Verification
The bench builds the block with the default `IDX_W` of 7, so element indices run up to 127. This reaches both extremes of the address range: an offset of 127 in 64-bit mode, and element groups that start mid-register and cross into the following register. The cases covered are:
- Unaligned starts at 16- and 32-bit widths, exercising the crossing path in both packer and splitter.
- A lane with only its high-register bytes enabled, which drives the `SP_IDLE` to `SP_WR_HI` path.
- A result offered during a pending write, which shows the busy rule at the ports.

// File: rtl/lanex_pkg.sv
package lanex_pkg;
    localparam int WORD_W    = 64;
    localparam int BYTES     = WORD_W / 8;
    localparam int MAX_LANES = BYTES;
    localparam int CNT_W     = $clog2(MAX_LANES + 1);
    localparam int BOFF_W    = $clog2(BYTES);

    typedef enum logic [1:0] {
        EW_8  = 2'd0,
        EW_16 = 2'd1,
        EW_32 = 2'd2,
        EW_64 = 2'd3
    } ew_e;

    // Lanes that exist for a given width code.
    function automatic logic [MAX_LANES-1:0] lanes_present(input logic [1:0] ew);
        logic [MAX_LANES-1:0] m;
        for (int i = 0; i < MAX_LANES; i++) begin
            m[i] = (i < (MAX_LANES >> ew));
        end
        return m;
    endfunction

    // Expand a lane enable to one bit per byte of the packed word.
    function automatic logic [BYTES-1:0] lanes_to_bytes(input logic [1:0] ew,
                                                        input logic [MAX_LANES-1:0] en);
        logic [BYTES-1:0] be;
        for (int b = 0; b < BYTES; b++) begin
            be[b] = en[BOFF_W'(b >> ew)];
        end
        return be;
    endfunction
endpackage

// File: rtl/lane_geom.sv
module lane_geom
    import lanex_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic [1:0]        ew,
    input  logic [IDX_W-1:0]  start,
    output logic [IDX_W-1:0]  reg_off,
    output logic [BOFF_W-1:0] byte_off
);
    // start * (w/8) gives the byte address of the first element
    logic [IDX_W+BOFF_W-1:0] byte_addr;

    always_comb begin
        byte_addr = {{BOFF_W{1'b0}}, start} << ew;
        reg_off   = byte_addr[IDX_W+BOFF_W-1:BOFF_W];
        byte_off  = byte_addr[BOFF_W-1:0];
    end
endmodule

// File: rtl/lane_packer.sv
module lane_packer
    import lanex_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid,
    input  logic [1:0]           ew,
    input  logic [CNT_W-1:0]     count,
    input  logic [MAX_LANES-1:0] pred,
    input  logic [WORD_W-1:0]    src_lo,
    input  logic [WORD_W-1:0]    src_hi,
    input  logic [BOFF_W-1:0]    byte_off,
    output logic                 op_valid,
    output logic [WORD_W-1:0]    op_data,
    output logic [MAX_LANES-1:0] op_lane_en
);
    logic [MAX_LANES-1:0] cnt_mask;
    logic [MAX_LANES-1:0] lane_en;
    logic [BYTES-1:0]     byte_en;
    logic [2*WORD_W-1:0]  window;
    logic [WORD_W-1:0]    packed_d;

    always_comb begin
        for (int i = 0; i < MAX_LANES; i++) begin
            cnt_mask[i] = (i < int'(count));
        end
        lane_en = lanes_present(ew) & cnt_mask & pred;
        byte_en = lanes_to_bytes(ew, lane_en);
        window  = {src_hi, src_lo} >> {byte_off, 3'b000};
    end

    for (genvar b = 0; b < BYTES; b++) begin : g_byte_mask
        assign packed_d[8*b +: 8] = byte_en[b] ? window[8*b +: 8] : 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_valid   <= 1'b0;
            op_data    <= '0;
            op_lane_en <= '0;
        end else begin
            op_valid <= valid;
            if (valid) begin
                op_data    <= packed_d;
                op_lane_en <= lane_en;
            end
        end
    end
endmodule

// File: rtl/lane_splitter.sv
module lane_splitter
    import lanex_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 res_valid,
    input  logic [1:0]           res_ew,
    input  logic [MAX_LANES-1:0] res_lane_en,
    input  logic [WORD_W-1:0]    res_data,
    input  logic [IDX_W-1:0]     reg_off,
    input  logic [BOFF_W-1:0]    byte_off,
    output logic                 res_ready,
    output logic                 wr_valid,
    output logic [IDX_W-1:0]     wr_reg_off,
    output logic [WORD_W-1:0]    wr_data,
    output logic [BYTES-1:0]     wr_be
);
    typedef enum logic [1:0] {
        SP_IDLE  = 2'd0,
        SP_WR_LO = 2'd1,
        SP_WR_HI = 2'd2
    } sp_state_e;

    sp_state_e st, st_nx;

    logic [BYTES-1:0]    be_packed;
    logic [2*BYTES-1:0]  be_wide;
    logic [2*WORD_W-1:0] d_wide;
    logic                take;

    logic [IDX_W-1:0]  h_off;
    logic [WORD_W-1:0] h_d_lo, h_d_hi;
    logic [BYTES-1:0]  h_be_lo, h_be_hi;

    always_comb begin
        be_packed = lanes_to_bytes(res_ew, res_lane_en & lanes_present(res_ew));
        be_wide   = {{BYTES{1'b0}}, be_packed} << byte_off;
        d_wide    = {{WORD_W{1'b0}}, res_data} << {byte_off, 3'b000};
        take      = res_valid && (st == SP_IDLE);
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            SP_IDLE: begin
                if (take) begin
                    if (be_wide[BYTES-1:0] != '0)            st_nx = SP_WR_LO;
                    else if (be_wide[2*BYTES-1:BYTES] != '0) st_nx = SP_WR_HI;
                    else                                     st_nx = SP_IDLE;
                end
            end
            SP_WR_LO: st_nx = (h_be_hi != '0) ? SP_WR_HI : SP_IDLE;
            SP_WR_HI: st_nx = SP_IDLE;
            default:  st_nx = SP_IDLE;
        endcase
    end

    // state register and capture of the scattered result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= SP_IDLE;
            h_off   <= '0;
            h_d_lo  <= '0;
            h_d_hi  <= '0;
            h_be_lo <= '0;
            h_be_hi <= '0;
        end else begin
            st <= st_nx;
            if (take) begin
                h_off   <= reg_off;
                h_d_lo  <= d_wide[WORD_W-1:0];
                h_d_hi  <= d_wide[2*WORD_W-1:WORD_W];
                h_be_lo <= be_wide[BYTES-1:0];
                h_be_hi <= be_wide[2*BYTES-1:BYTES];
            end
        end
    end

    // outputs decoded from the state
    always_comb begin
        res_ready  = 1'b0;
        wr_valid   = 1'b0;
        wr_reg_off = h_off;
        wr_data    = h_d_lo;
        wr_be      = '0;
        unique case (st)
            SP_IDLE: res_ready = 1'b1;
            SP_WR_LO: begin
                wr_valid = 1'b1;
                wr_be    = h_be_lo;
            end
            SP_WR_HI: begin
                wr_valid   = 1'b1;
                wr_reg_off = h_off + IDX_W'(1);
                wr_data    = h_d_hi;
                wr_be      = h_be_hi;
            end
            default: res_ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/subword_lane_xbar.sv
module subword_lane_xbar
    import lanex_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pk_valid,
    input  logic [1:0]           pk_ew,
    input  logic [IDX_W-1:0]     pk_start,
    input  logic [CNT_W-1:0]     pk_count,
    input  logic [MAX_LANES-1:0] pk_pred,
    input  logic [WORD_W-1:0]    pk_src_lo,
    input  logic [WORD_W-1:0]    pk_src_hi,
    output logic [IDX_W-1:0]     pk_reg_off,
    output logic                 op_valid,
    output logic [WORD_W-1:0]    op_data,
    output logic [MAX_LANES-1:0] op_lane_en,
    input  logic                 res_valid,
    output logic                 res_ready,
    input  logic [1:0]           res_ew,
    input  logic [IDX_W-1:0]     res_start,
    input  logic [MAX_LANES-1:0] res_lane_en,
    input  logic [WORD_W-1:0]    res_data,
    output logic                 wr_valid,
    output logic [IDX_W-1:0]     wr_reg_off,
    output logic [WORD_W-1:0]    wr_data,
    output logic [BYTES-1:0]     wr_be
);
    logic [BOFF_W-1:0] pk_boff;
    logic [IDX_W-1:0]  sp_off;
    logic [BOFF_W-1:0] sp_boff;

    lane_geom #(.IDX_W(IDX_W)) u_geom_pk (
        .ew       (pk_ew),
        .start    (pk_start),
        .reg_off  (pk_reg_off),
        .byte_off (pk_boff)
    );

    lane_geom #(.IDX_W(IDX_W)) u_geom_sp (
        .ew       (res_ew),
        .start    (res_start),
        .reg_off  (sp_off),
        .byte_off (sp_boff)
    );

    lane_packer u_packer (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid      (pk_valid),
        .ew         (pk_ew),
        .count      (pk_count),
        .pred       (pk_pred),
        .src_lo     (pk_src_lo),
        .src_hi     (pk_src_hi),
        .byte_off   (pk_boff),
        .op_valid   (op_valid),
        .op_data    (op_data),
        .op_lane_en (op_lane_en)
    );

    lane_splitter #(.IDX_W(IDX_W)) u_splitter (
        .clk         (clk),
        .rst_n       (rst_n),
        .res_valid   (res_valid),
        .res_ew      (res_ew),
        .res_lane_en (res_lane_en),
        .res_data    (res_data),
        .reg_off     (sp_off),
        .byte_off    (sp_boff),
        .res_ready   (res_ready),
        .wr_valid    (wr_valid),
        .wr_reg_off  (wr_reg_off),
        .wr_data     (wr_data),
        .wr_be       (wr_be)
    );
endmodule

// File: rtl/subword_lane_xbar_chk.sv
module subword_lane_xbar_chk
    import lanex_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 pk_valid,
    input logic [1:0]           pk_ew,
    input logic                 op_valid,
    input logic [WORD_W-1:0]    op_data,
    input logic [MAX_LANES-1:0] op_lane_en,
    input logic                 res_valid,
    input logic                 res_ready,
    input logic [1:0]           res_ew,
    input logic [MAX_LANES-1:0] res_lane_en,
    input logic                 wr_valid,
    input logic [IDX_W-1:0]     wr_reg_off,
    input logic [BYTES-1:0]     wr_be
);
    // R2
    op_valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pk_valid |=> op_valid);

    // R2
    op_idle_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pk_valid |=> !op_valid);

    // R3
    lane_en_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> ((op_lane_en & ~lanes_present($past(pk_ew))) == '0));

    // R4
    dead_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> ((op_data & ~{<<8{{<<{lanes_to_bytes($past(pk_ew), op_lane_en)}}}}) == '0)
                     || 1'b1 && ((op_data & byte_mask(lanes_to_bytes($past(pk_ew), op_lane_en))) == op_data));

    // R6
    accepted_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_ready && ((res_lane_en & lanes_present(res_ew)) != '0)) |=> wr_valid);

    // R7
    second_write_next_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && $past(wr_valid)) |-> (wr_reg_off == $past(wr_reg_off) + IDX_W'(1)));

    // R8
    no_empty_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_be != '0));

    // R9
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !res_ready);

    function automatic logic [WORD_W-1:0] byte_mask(input logic [BYTES-1:0] be);
        logic [WORD_W-1:0] m;
        for (int b = 0; b < BYTES; b++) begin
            m[8*b +: 8] = {8{be[b]}};
        end
        return m;
    endfunction
endmodule

bind subword_lane_xbar subword_lane_xbar_chk #(.IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pk_valid    (pk_valid),
    .pk_ew       (pk_ew),
    .op_valid    (op_valid),
    .op_data     (op_data),
    .op_lane_en  (op_lane_en),
    .res_valid   (res_valid),
    .res_ready   (res_ready),
    .res_ew      (res_ew),
    .res_lane_en (res_lane_en),
    .wr_valid    (wr_valid),
    .wr_reg_off  (wr_reg_off),
    .wr_be       (wr_be)
);

// File: tb/tb_subword_lane_xbar.sv
module tb_subword_lane_xbar;
    import lanex_pkg::*;

    localparam int IDX_W = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pk_valid = 1'b0;
    logic [1:0]        pk_ew = '0;
    logic [IDX_W-1:0]  pk_start = '0;
    logic [3:0]        pk_count = '0;
    logic [7:0]        pk_pred = '0;
    logic [63:0]       pk_src_lo = '0, pk_src_hi = '0;
    logic [IDX_W-1:0]  pk_reg_off;
    logic              op_valid;
    logic [63:0]       op_data;
    logic [7:0]        op_lane_en;
    logic              res_valid = 1'b0;
    logic              res_ready;
    logic [1:0]        res_ew = '0;
    logic [IDX_W-1:0]  res_start = '0;
    logic [7:0]        res_lane_en = '0;
    logic [63:0]       res_data = '0;
    logic              wr_valid;
    logic [IDX_W-1:0]  wr_reg_off;
    logic [63:0]       wr_data;
    logic [7:0]        wr_be;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    subword_lane_xbar #(.IDX_W(IDX_W)) dut (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] be_bits(input logic [7:0] be);
        logic [63:0] m;
        for (int b = 0; b < 8; b++) m[8*b +: 8] = {8{be[b]}};
        return m;
    endfunction

    // Element-by-element model of the packer.
    function automatic void model_pack(input int ew, input int s, input int cnt,
                                       input logic [7:0] pred, input logic [63:0] lo,
                                       input logic [63:0] hi, output logic [63:0] d,
                                       output logic [7:0] en);
        int w = 8 << ew;
        int lanes = 8 >> ew;
        int base = (s * w) / 64;
        d = '0;
        en = '0;
        for (int i = 0; i < lanes; i++) begin
            if (i < cnt && pred[i]) begin
                int gb = (s + i) * w;
                int r  = gb / 64 - base;
                int ob = gb % 64;
                en[i] = 1'b1;
                for (int k = 0; k < w; k++) d[i*w + k] = (r == 0) ? lo[ob + k] : hi[ob + k];
            end
        end
    endfunction

    // Element-by-element model of the splitter.
    function automatic void model_split(input int ew, input int s, input logic [7:0] en,
                                        input logic [63:0] data,
                                        output logic [63:0] dl, output logic [7:0] bl,
                                        output logic [63:0] dh, output logic [7:0] bh);
        int w = 8 << ew;
        int lanes = 8 >> ew;
        int base = (s * w) / 64;
        dl = '0; dh = '0; bl = '0; bh = '0;
        for (int i = 0; i < lanes; i++) begin
            if (en[i]) begin
                int gb = (s + i) * w;
                int r  = gb / 64 - base;
                int ob = (gb % 64) / 8;
                for (int k = 0; k < w / 8; k++) begin
                    if (r == 0) begin
                        bl[ob + k] = 1'b1;
                        dl[8*(ob + k) +: 8] = data[8*(i*(w/8) + k) +: 8];
                    end else begin
                        bh[ob + k] = 1'b1;
                        dh[8*(ob + k) +: 8] = data[8*(i*(w/8) + k) +: 8];
                    end
                end
            end
        end
    endfunction

    task automatic t_reset();
        check(op_valid == 1'b0, "R10", "op_valid after reset", 64'(op_valid), 64'd0);
        check(wr_valid == 1'b0, "R10", "wr_valid after reset", 64'(wr_valid), 64'd0);
        check(res_ready == 1'b1, "R10", "res_ready after reset", 64'(res_ready), 64'd1);
    endtask

    task automatic t_pack(input int ew, input int s, input int cnt, input logic [7:0] pred,
                          input logic [63:0] lo, input logic [63:0] hi, input string req);
        logic [63:0] ed;
        logic [7:0]  ee;
        model_pack(ew, s, cnt, pred, lo, hi, ed, ee);
        @(negedge clk);
        pk_ew = 2'(ew); pk_start = IDX_W'(s); pk_count = 4'(cnt); pk_pred = pred;
        pk_src_lo = lo; pk_src_hi = hi; pk_valid = 1'b1;
        #1;
        check(pk_reg_off == IDX_W'((s * (8 << ew)) / 64), "R1", "pk_reg_off",
              64'(pk_reg_off), 64'((s * (8 << ew)) / 64));
        @(negedge clk);
        pk_valid = 1'b0;
        check(op_valid == 1'b1, "R2", "op_valid", 64'(op_valid), 64'd1);
        check(op_lane_en == ee, "R3", "op_lane_en", 64'(op_lane_en), 64'(ee));
        check(op_data == ed, req, "op_data", op_data, ed);
        @(negedge clk);
        check(op_valid == 1'b0, "R2", "op_valid drop", 64'(op_valid), 64'd0);
    endtask

    // Offers one result and compares the writes seen over three cycles.
    task automatic t_split(input int ew, input int s, input logic [7:0] en,
                           input logic [63:0] data, input string req);
        logic [63:0] dl, dh;
        logic [7:0]  bl, bh, en_ok;
        int base, n_exp, n_got;
        logic [IDX_W-1:0] g_off [3];
        logic [63:0]      g_d   [3];
        logic [7:0]       g_be  [3];
        en_ok = en & ((8'h1 << (8 >> ew)) - 8'h1);
        model_split(ew, s, en_ok, data, dl, bl, dh, bh);
        base  = (s * (8 << ew)) / 64;
        n_exp = int'(bl != 0) + int'(bh != 0);
        n_got = 0;
        @(negedge clk);
        check(res_ready == 1'b1, "R9", "ready before offer", 64'(res_ready), 64'd1);
        res_ew = 2'(ew); res_start = IDX_W'(s); res_lane_en = en; res_data = data;
        res_valid = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
        for (int c = 0; c < 3; c++) begin
            if (c > 0) @(negedge clk);
            if (wr_valid) begin
                if (n_got < 3) begin
                    g_off[n_got] = wr_reg_off; g_d[n_got] = wr_data; g_be[n_got] = wr_be;
                end
                n_got++;
            end
        end
        check(n_got == n_exp, "R8", "write count", 64'(n_got), 64'(n_exp));
        if (n_got == n_exp) begin
            int k = 0;
            if (bl != 0) begin
                check(g_off[k] == IDX_W'(base), req, "low offset", 64'(g_off[k]), 64'(base));
                check(g_be[k] == bl, req, "low be", 64'(g_be[k]), 64'(bl));
                check((g_d[k] & be_bits(bl)) == dl, req, "low data",
                      g_d[k] & be_bits(bl), dl);
                k++;
            end
            if (bh != 0) begin
                check(g_off[k] == IDX_W'(base + 1), "R7", "high offset",
                      64'(g_off[k]), 64'(base + 1));
                check(g_be[k] == bh, "R7", "high be", 64'(g_be[k]), 64'(bh));
                check((g_d[k] & be_bits(bh)) == dh, "R7", "high data",
                      g_d[k] & be_bits(bh), dh);
            end
        end
    endtask

    // A second result offered while a write is pending must be dropped.
    task automatic t_busy();
        int n_got = 0;
        @(negedge clk);
        res_ew = 2'(EW_8); res_start = IDX_W'(5); res_lane_en = 8'hFF;
        res_data = 64'h8877_6655_4433_2211; res_valid = 1'b1;
        @(negedge clk);
        if (wr_valid) n_got++;
        res_start = IDX_W'(40); res_data = 64'hDEAD_BEEF_0000_1111;
        check(res_ready == 1'b0, "R9", "ready while busy", 64'(res_ready), 64'd0);
        @(negedge clk);
        res_valid = 1'b0;
        if (wr_valid) n_got++;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            if (wr_valid) n_got++;
        end
        check(n_got == 2, "R9", "writes with busy offer", 64'(n_got), 64'd2);
        check(res_ready == 1'b1, "R9", "ready after drain", 64'(res_ready), 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        // R2: aligned byte lanes at register offset 2
        t_pack(0, 16, 8, 8'hFF, 64'h0F0E_0D0C_0B0A_0908, 64'h1716_1514_1312_1110, "R2");
        // R2: 16-bit group crossing into the next register
        t_pack(1, 6, 4, 8'h0F, 64'hAAAA_BBBB_CCCC_DDDD, 64'h1111_2222_3333_4444, "R2");
        // R2: 32-bit group crossing
        t_pack(2, 3, 2, 8'h03, 64'h7654_3210_FEDC_BA98, 64'h0123_4567_89AB_CDEF, "R2");
        // R4: count and predicate both thin the lanes
        t_pack(0, 3, 3, 8'hB6, 64'h0807_0605_0403_0201, 64'h100F_0E0D_0C0B_0A09, "R4");
        // R3: predicate bits beyond two 32-bit lanes are dropped
        t_pack(2, 2, 8, 8'hFF, 64'h5555_6666_7777_8888, 64'h9999_AAAA_BBBB_CCCC, "R3");
        // R5: 64-bit pass-through at the highest index
        t_pack(3, 127, 1, 8'h01, 64'hC0FF_EE00_1234_5678, 64'hFFFF_FFFF_FFFF_FFFF, "R5");
        // R4: 64-bit lane switched off gives zero data
        t_pack(3, 9, 1, 8'h00, 64'hC0FF_EE00_1234_5678, 64'h0, "R4");
        // R6: 16-bit result crossing into the next register
        t_split(1, 6, 8'h0F, 64'h4444_3333_2222_1111, "R6");
        // R6: aligned byte result, one write only
        t_split(0, 8, 8'h05, 64'h0807_0605_0403_0201, "R6");
        // R7: only the upper lane lands, and it lands in the next register
        t_split(2, 1, 8'h02, 64'hAABB_CCDD_1122_3344, "R7");
        // R8: no lane enabled, no write
        t_split(0, 3, 8'h00, 64'h1234_5678_9ABC_DEF0, "R8");
        // R11: lanes above the single 64-bit lane are ignored
        t_split(3, 100, 8'hFE, 64'h1111_2222_3333_4444, "R11");
        t_split(3, 100, 8'hFF, 64'h1111_2222_3333_4444, "R11");
        // R9: second offer during a pending write
        t_busy();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule